// File: doc/BRIEF.md
# Outstanding Miss Entry with Target Queues

This block is one entry of a miss tracking table in a non-blocking coherent cache. When a miss is allocated, the entry stores the line address and the first waiting request. Later requests to the same line are queued behind it. While the miss is being serviced downstream, the entry holds the coherence facts about the expected fill: whether it will arrive modified, and so both owned and writable. It also records whether an invalidating snoop or a reading snoop was seen while the miss was outstanding.

Requests that need a writable copy cannot be satisfied by a fill that will not grant write permission. Such requests are parked in a second, deferred queue. After the primary queue has drained, they can be promoted as a group. When an invalidating snoop arrives while the miss is not yet in service, queued upgrade requests are rewritten as read-exclusive requests, and store-conditional requests are rewritten as failures.

The surrounding cache controller drives one operation per cycle. It reads back the head target, the target count and the status flags from the outputs.

Top module: `miss_track_entry`

## Requirements
- R1: After reset, and one cycle after `dealloc_i`, the entry shows `valid_o`=0, `in_svc_o`=0, all coherence and queue flags 0, `tgt_count_o`=0 and `has_tgt_o`=0.
- R2: `alloc_i` makes the entry valid, latches `alloc_addr_i` on `addr_o`, clears the in-service state and leaves exactly the supplied target in the primary queue.
- R3: Targets leave the primary queue through `pop_i` in arrival order, with the id, ready time, order number, source code (0 CPU, 1 snoop, 2 prefetcher), marked-pending bit and kind all intact.
- R4: `svc_i` on a valid entry that is not in service sets `in_svc_o` and latches `svc_pend_mod_i` on `pend_mod_o`. While the entry is in service, `snp_inv_i` sets `post_inv_o` and `snp_rd_i` sets `post_dg_o`. `fill_i` ends service and clears all three flags. Snoops outside service never set these flags.
- R5: `rd_flags_i` pulses `flag_err_o` on the next cycle exactly when the entry is not in service.
- R6: A target whose kind needs a writable copy goes to the deferred queue when the entry is in service and `pend_mod_o` is 0. Every other target goes to the primary queue. Kind encoding: 0 read, 1 read-exclusive, 2 upgrade, 3 store-conditional, 4 store-conditional failure. Kinds 1, 2 and 3 need a writable copy.
- R7: Each queue raises its needs-writable flag when a kind 1–3 target enters it, and raises its has-upgrade flag when a kind 2–3 target enters it. Clearing the queue (allocate, deallocate, or promotion for the deferred queue) drops both flags.
- R8: An invalidating snoop on a valid entry that is not in service rewrites kind 2 as kind 1 and kind 3 as kind 4 in both queues, and drops both has-upgrade flags.
- R9: `tgt_count_o` equals the primary count plus the deferred count. `has_tgt_o` is 1 exactly when the primary queue is non-empty.
- R10: `promote_i` with an empty primary queue and a non-empty deferred queue moves every deferred target into the primary queue in order, carries its flags along and pulses `promote_ok_o` on the next cycle. In any other case nothing changes and `promote_ok_o` stays 0.
- R11: An add aimed at a full queue (DEPTH targets) pulses `stall_o` on the next cycle and leaves both queues unchanged.
- R12: `pop_i` with an empty primary queue pulses `pop_err_o` on the next cycle and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_i | input | 1 | Allocate the entry, with the target fields as the first target |
| alloc_addr_i | input | ADDR_W | Line address for allocation |
| add_i | input | 1 | Queue the target fields as a new target |
| tgt_id_i | input | 8 | Request id of the incoming target |
| tgt_ready_i | input | 16 | Ready time of the incoming target |
| tgt_order_i | input | 16 | Global order number of the incoming target |
| tgt_src_i | input | 2 | Source code of the incoming target |
| tgt_mark_i | input | 1 | Incoming target marked an upstream entry as downstream-pending |
| tgt_kind_i | input | 3 | Request kind of the incoming target |
| svc_i | input | 1 | Mark the entry in service |
| svc_pend_mod_i | input | 1 | The expected fill will be modified (owned and writable) |
| snp_inv_i | input | 1 | Invalidating snoop to this line |
| snp_rd_i | input | 1 | Reading snoop to this line |
| fill_i | input | 1 | Fill response returned; service ends |
| rd_flags_i | input | 1 | Controller consumes the in-service flags |
| promote_i | input | 1 | Promote deferred targets |
| pop_i | input | 1 | Remove the head target |
| dealloc_i | input | 1 | Free the entry |
| valid_o | output | 1 | Entry is allocated |
| addr_o | output | ADDR_W | Stored line address |
| in_svc_o | output | 1 | Miss is in service |
| pend_mod_o | output | 1 | Pending-modified flag |
| post_inv_o | output | 1 | Invalidating snoop seen in service |
| post_dg_o | output | 1 | Reading snoop seen in service |
| flag_err_o | output | 1 | Flags were read outside service |
| head_id_o | output | 8 | Head target id |
| head_ready_o | output | 16 | Head target ready time |
| head_order_o | output | 16 | Head target order number |
| head_src_o | output | 2 | Head target source code |
| head_mark_o | output | 1 | Head target marked-pending bit |
| head_kind_o | output | 3 | Head target kind |
| tgt_count_o | output | CNT_W+1 | Total queued targets |
| has_tgt_o | output | 1 | Primary queue non-empty |
| prim_nw_o | output | 1 | Primary queue needs-writable flag |
| prim_hu_o | output | 1 | Primary queue has-upgrade flag |
| def_nw_o | output | 1 | Deferred queue needs-writable flag |
| def_hu_o | output | 1 | Deferred queue has-upgrade flag |
| stall_o | output | 1 | Previous add was refused because the target queue was full |
| pop_err_o | output | 1 | Previous pop found the primary queue empty |
| promote_ok_o | output | 1 | Previous promotion moved targets |

## Verification
A target routed to the wrong queue shows up at once on `has_tgt_o` and the queue flags. It also shows up later as a wrong head order after the fill and the promotion. A lost or duplicated target changes `tgt_count_o` in the cycle after the add or pop. A corrupted shift shows the wrong head fields on the very next pop. A missed kind rewrite or flag latch is seen one cycle after the snoop or service command, through `head_kind_o`, `prim_hu_o` or the post flags. A stale in-service bit is exposed by the next `rd_flags_i` through `flag_err_o`.

// File: rtl/mte_pkg.sv
// Shared widths, kind codes and target record for the miss entry.
// Assumes every target field fits the widths below.
package mte_pkg;
    parameter int unsigned ID_W   = 8;
    parameter int unsigned TIME_W = 16;
    parameter int unsigned ORD_W  = 16;

    localparam logic [2:0] K_READ   = 3'd0;
    localparam logic [2:0] K_READEX = 3'd1;
    localparam logic [2:0] K_UPG    = 3'd2;
    localparam logic [2:0] K_SC     = 3'd3;
    localparam logic [2:0] K_SCFAIL = 3'd4;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [TIME_W-1:0] ready;
        logic [ORD_W-1:0]  order;
        logic [1:0]        src;
        logic              mark;
        logic [2:0]        kind;
    } tgt_t;

    // A kind that can only be served by a writable copy.
    function automatic logic kind_needs_wr(input logic [2:0] k);
        return (k == K_READEX) || (k == K_UPG) || (k == K_SC);
    endfunction

    // A kind that presumes the line is still present.
    function automatic logic kind_is_upg(input logic [2:0] k);
        return (k == K_UPG) || (k == K_SC);
    endfunction
endpackage

// File: rtl/mte_target_fifo.sv
// Shift-style target queue: slot 0 is the head. In one cycle it applies,
// in order: clear or bulk load, kind rewrite, pop, push.
// Assumes the caller never pushes while full (push is then dropped).
module mte_target_fifo
    import mte_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 load_i,
    input  tgt_t [DEPTH-1:0]     load_ents_i,
    input  logic [CNT_W-1:0]     load_cnt_i,
    input  logic                 load_nw_i,
    input  logic                 load_hu_i,
    input  logic                 conv_i,
    input  logic                 pop_i,
    input  logic                 push_i,
    input  tgt_t                 push_tgt_i,
    output tgt_t [DEPTH-1:0]     ents_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic                 full_o,
    output logic                 empty_o,
    output logic                 nw_o,
    output logic                 hu_o
);
    tgt_t [DEPTH-1:0] ents_q, ents_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             nw_q, nw_n, hu_q, hu_n;

    // Next-state of the queue from this cycle's commands.
    always_comb begin
        ents_n = ents_q;
        cnt_n  = cnt_q;
        nw_n   = nw_q;
        hu_n   = hu_q;
        if (clr_i) begin
            cnt_n = '0;
            nw_n  = 1'b0;
            hu_n  = 1'b0;
        end else if (load_i) begin
            ents_n = load_ents_i;
            cnt_n  = load_cnt_i;
            nw_n   = load_nw_i;
            hu_n   = load_hu_i;
        end
        if (conv_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ents_n[i].kind == K_UPG)     ents_n[i].kind = K_READEX;
                else if (ents_n[i].kind == K_SC) ents_n[i].kind = K_SCFAIL;
            end
            hu_n = 1'b0;
        end
        if (pop_i && (cnt_n != '0)) begin
            for (int i = 0; i < DEPTH - 1; i++) ents_n[i] = ents_n[i+1];
            cnt_n = cnt_n - 1'b1;
        end
        if (push_i && (cnt_n < CNT_W'(DEPTH))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == cnt_n) ents_n[i] = push_tgt_i;
            end
            cnt_n = cnt_n + 1'b1;
            nw_n  = nw_n | kind_needs_wr(push_tgt_i.kind);
            hu_n  = hu_n | kind_is_upg(push_tgt_i.kind);
        end
    end

    // Queue state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
            cnt_q  <= '0;
            nw_q   <= 1'b0;
            hu_q   <= 1'b0;
        end else begin
            ents_q <= ents_n;
            cnt_q  <= cnt_n;
            nw_q   <= nw_n;
            hu_q   <= hu_n;
        end
    end

    assign ents_o  = ents_q;
    assign cnt_o   = cnt_q;
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign nw_o    = nw_q;
    assign hu_o    = hu_q;

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_W'(DEPTH));
    a_r7_clear_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !push_i |=> empty_o && !nw_o && !hu_o);
    a_r3_pop_shifts_head: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !clr_i && !load_i && !conv_i && !push_i && (cnt_o > 1)
        |=> ents_o[0] == $past(ents_o[1]));
    a_r12_pop_empty_still: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && empty_o && !clr_i && !load_i && !push_i |=> empty_o);
endmodule

// File: rtl/mte_state_ctl.sv
// Lifecycle and coherence flags of the entry: valid, in-service,
// pending-modified, post-invalidate, post-downgrade, and the
// flag-read-outside-service error pulse.
// Assumes deallocate beats allocate, and both beat every other command.
module mte_state_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic dealloc_i,
    input  logic alloc_i,
    input  logic svc_i,
    input  logic svc_pm_i,
    input  logic snp_inv_i,
    input  logic snp_rd_i,
    input  logic fill_i,
    input  logic rd_flags_i,
    output logic valid_o,
    output logic in_svc_o,
    output logic pend_mod_o,
    output logic post_inv_o,
    output logic post_dg_o,
    output logic flag_err_o
);
    logic valid_q, svc_q, pm_q, pinv_q, pdg_q, ferr_q;
    logic live, svc_go, fill_go;

    assign live    = !dealloc_i && !alloc_i && valid_q;
    assign svc_go  = live && svc_i && !svc_q;
    assign fill_go = live && fill_i && svc_q;

    // Entry lifecycle and in-service flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            svc_q   <= 1'b0;
            pm_q    <= 1'b0;
            pinv_q  <= 1'b0;
            pdg_q   <= 1'b0;
        end else if (dealloc_i || alloc_i) begin
            valid_q <= alloc_i && !dealloc_i;
            svc_q   <= 1'b0;
            pm_q    <= 1'b0;
            pinv_q  <= 1'b0;
            pdg_q   <= 1'b0;
        end else if (svc_go) begin
            svc_q   <= 1'b1;
            pm_q    <= svc_pm_i;
            pinv_q  <= 1'b0;
            pdg_q   <= 1'b0;
        end else if (fill_go) begin
            svc_q   <= 1'b0;
            pm_q    <= 1'b0;
            pinv_q  <= 1'b0;
            pdg_q   <= 1'b0;
        end else if (live && svc_q) begin
            pinv_q  <= pinv_q | snp_inv_i;
            pdg_q   <= pdg_q | snp_rd_i;
        end
    end

    // Error pulse for a flag read outside service.
    always_ff @(posedge clk) begin
        if (!rst_n) ferr_q <= 1'b0;
        else        ferr_q <= rd_flags_i && !svc_q;
    end

    assign valid_o    = valid_q;
    assign in_svc_o   = svc_q;
    assign pend_mod_o = pm_q;
    assign post_inv_o = pinv_q;
    assign post_dg_o  = pdg_q;
    assign flag_err_o = ferr_q;

    a_r4_service_latch: assert property (@(posedge clk) disable iff (!rst_n)
        svc_go |=> in_svc_o && (pend_mod_o == $past(svc_pm_i)));
    a_r4_post_only_in_svc: assert property (@(posedge clk) disable iff (!rst_n)
        (post_inv_o || post_dg_o) |-> in_svc_o);
    a_r5_flag_err: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flags_i && !in_svc_o |=> flag_err_o);
    a_r1_dealloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dealloc_i |=> !valid_o && !in_svc_o && !pend_mod_o);
endmodule

// File: rtl/miss_track_entry.sv
// One outstanding-miss entry: line address, primary and deferred target
// queues, coherence flags, routing of writable requests, promotion and
// upgrade rewriting.
// Assumes the controller issues one command per cycle; deallocate and
// allocate take priority, and promotion claims the cycle over add and pop.
module miss_track_entry
    import mte_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic [ADDR_W-1:0]  alloc_addr_i,
    input  logic               add_i,
    input  logic [ID_W-1:0]    tgt_id_i,
    input  logic [TIME_W-1:0]  tgt_ready_i,
    input  logic [ORD_W-1:0]   tgt_order_i,
    input  logic [1:0]         tgt_src_i,
    input  logic               tgt_mark_i,
    input  logic [2:0]         tgt_kind_i,
    input  logic               svc_i,
    input  logic               svc_pend_mod_i,
    input  logic               snp_inv_i,
    input  logic               snp_rd_i,
    input  logic               fill_i,
    input  logic               rd_flags_i,
    input  logic               promote_i,
    input  logic               pop_i,
    input  logic               dealloc_i,
    output logic               valid_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               in_svc_o,
    output logic               pend_mod_o,
    output logic               post_inv_o,
    output logic               post_dg_o,
    output logic               flag_err_o,
    output logic [ID_W-1:0]    head_id_o,
    output logic [TIME_W-1:0]  head_ready_o,
    output logic [ORD_W-1:0]   head_order_o,
    output logic [1:0]         head_src_o,
    output logic               head_mark_o,
    output logic [2:0]         head_kind_o,
    output logic [CNT_W:0]     tgt_count_o,
    output logic               has_tgt_o,
    output logic               prim_nw_o,
    output logic               prim_hu_o,
    output logic               def_nw_o,
    output logic               def_hu_o,
    output logic               stall_o,
    output logic               pop_err_o,
    output logic               promote_ok_o
);
    tgt_t             tgt_in;
    tgt_t [DEPTH-1:0] p_ents, d_ents;
    logic [CNT_W-1:0] p_cnt, d_cnt;
    logic             p_full, p_empty, d_full, d_empty;
    logic             in_svc, pm, valid;
    logic             ops_en, to_def, dest_full;
    logic             add_ok, add_blk, pop_ok, pop_bad, prom_ok, conv;
    logic             p_clr, p_push, d_clr, d_push;
    logic [ADDR_W-1:0] addr_q;
    logic             stall_q, pop_err_q, prom_q;

    assign tgt_in = '{id: tgt_id_i, ready: tgt_ready_i, order: tgt_order_i,
                      src: tgt_src_i, mark: tgt_mark_i, kind: tgt_kind_i};

    // Command qualification and queue routing.
    always_comb begin
        ops_en    = valid && !dealloc_i && !alloc_i;
        to_def    = kind_needs_wr(tgt_kind_i) && in_svc && !pm;
        dest_full = to_def ? d_full : p_full;
        prom_ok   = ops_en && promote_i && p_empty && !d_empty;
        add_ok    = ops_en && add_i && !promote_i && !dest_full;
        add_blk   = ops_en && add_i && !promote_i && dest_full;
        pop_ok    = ops_en && pop_i && !promote_i && !p_empty;
        pop_bad   = pop_i && !dealloc_i && !alloc_i && !promote_i && p_empty;
        conv      = ops_en && snp_inv_i && !in_svc;
        p_clr     = dealloc_i || alloc_i;
        p_push    = (alloc_i && !dealloc_i) || (add_ok && !to_def);
        d_clr     = dealloc_i || alloc_i || prom_ok;
        d_push    = add_ok && to_def;
    end

    mte_state_ctl u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .dealloc_i  (dealloc_i),
        .alloc_i    (alloc_i),
        .svc_i      (svc_i),
        .svc_pm_i   (svc_pend_mod_i),
        .snp_inv_i  (snp_inv_i),
        .snp_rd_i   (snp_rd_i),
        .fill_i     (fill_i),
        .rd_flags_i (rd_flags_i),
        .valid_o    (valid),
        .in_svc_o   (in_svc),
        .pend_mod_o (pm),
        .post_inv_o (post_inv_o),
        .post_dg_o  (post_dg_o),
        .flag_err_o (flag_err_o)
    );

    mte_target_fifo #(.DEPTH(DEPTH)) u_prim (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (p_clr),
        .load_i      (prom_ok),
        .load_ents_i (d_ents),
        .load_cnt_i  (d_cnt),
        .load_nw_i   (def_nw_o),
        .load_hu_i   (def_hu_o),
        .conv_i      (conv),
        .pop_i       (pop_ok),
        .push_i      (p_push),
        .push_tgt_i  (tgt_in),
        .ents_o      (p_ents),
        .cnt_o       (p_cnt),
        .full_o      (p_full),
        .empty_o     (p_empty),
        .nw_o        (prim_nw_o),
        .hu_o        (prim_hu_o)
    );

    mte_target_fifo #(.DEPTH(DEPTH)) u_defer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (d_clr),
        .load_i      (1'b0),
        .load_ents_i ('0),
        .load_cnt_i  ('0),
        .load_nw_i   (1'b0),
        .load_hu_i   (1'b0),
        .conv_i      (conv),
        .pop_i       (1'b0),
        .push_i      (d_push),
        .push_tgt_i  (tgt_in),
        .ents_o      (d_ents),
        .cnt_o       (d_cnt),
        .full_o      (d_full),
        .empty_o     (d_empty),
        .nw_o        (def_nw_o),
        .hu_o        (def_hu_o)
    );

    // Line address register.
    always_ff @(posedge clk) begin
        if (!rst_n || dealloc_i) addr_q <= '0;
        else if (alloc_i)        addr_q <= alloc_addr_i;
    end

    // One-cycle result pulses for refused add, empty pop and promotion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q   <= 1'b0;
            pop_err_q <= 1'b0;
            prom_q    <= 1'b0;
        end else begin
            stall_q   <= add_blk;
            pop_err_q <= pop_bad;
            prom_q    <= prom_ok;
        end
    end

    assign valid_o      = valid;
    assign addr_o       = addr_q;
    assign in_svc_o     = in_svc;
    assign pend_mod_o   = pm;
    assign head_id_o    = p_ents[0].id;
    assign head_ready_o = p_ents[0].ready;
    assign head_order_o = p_ents[0].order;
    assign head_src_o   = p_ents[0].src;
    assign head_mark_o  = p_ents[0].mark;
    assign head_kind_o  = p_ents[0].kind;
    assign tgt_count_o  = {1'b0, p_cnt} + {1'b0, d_cnt};
    assign has_tgt_o    = !p_empty;
    assign stall_o      = stall_q;
    assign pop_err_o    = pop_err_q;
    assign promote_ok_o = prom_q;

    a_r6_defer_only_in_svc: assert property (@(posedge clk) disable iff (!rst_n)
        (d_cnt > $past(d_cnt)) |-> $past(in_svc) && !$past(pm));
    a_r11_stall_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o && !$past(pop_ok) |-> tgt_count_o == $past(tgt_count_o));
    a_r12_pop_err_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        pop_err_o && !$past(add_ok) |-> tgt_count_o == $past(tgt_count_o));
    a_r10_promote_fills_primary: assert property (@(posedge clk) disable iff (!rst_n)
        promote_ok_o |-> has_tgt_o && !def_nw_o && !def_hu_o);
    a_r9_has_implies_count: assert property (@(posedge clk) disable iff (!rst_n)
        has_tgt_o |-> tgt_count_o != '0);
endmodule

// File: tb/test_miss_track_entry.sv
`timescale 1ns/1ps
module test_miss_track_entry;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_i = 0, add_i = 0, svc_i = 0, svc_pend_mod_i = 0;
    logic snp_inv_i = 0, snp_rd_i = 0, fill_i = 0, rd_flags_i = 0;
    logic promote_i = 0, pop_i = 0, dealloc_i = 0, tgt_mark_i = 0;
    logic [31:0] alloc_addr_i = '0;
    logic [7:0]  tgt_id_i = '0;
    logic [15:0] tgt_ready_i = '0, tgt_order_i = '0;
    logic [1:0]  tgt_src_i = '0;
    logic [2:0]  tgt_kind_i = '0;
    logic        valid_o, in_svc_o, pend_mod_o, post_inv_o, post_dg_o, flag_err_o;
    logic [31:0] addr_o;
    logic [7:0]  head_id_o;
    logic [15:0] head_ready_o, head_order_o;
    logic [1:0]  head_src_o;
    logic        head_mark_o;
    logic [2:0]  head_kind_o;
    logic [4:0]  tgt_count_o;
    logic        has_tgt_o, prim_nw_o, prim_hu_o, def_nw_o, def_hu_o;
    logic        stall_o, pop_err_o, promote_ok_o;

    always #4 clk = ~clk;

    miss_track_entry #(.ADDR_W(32), .DEPTH(DEPTH)) i_miss_track_entry (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .alloc_addr_i(alloc_addr_i),
        .add_i(add_i), .tgt_id_i(tgt_id_i), .tgt_ready_i(tgt_ready_i),
        .tgt_order_i(tgt_order_i), .tgt_src_i(tgt_src_i), .tgt_mark_i(tgt_mark_i),
        .tgt_kind_i(tgt_kind_i), .svc_i(svc_i), .svc_pend_mod_i(svc_pend_mod_i),
        .snp_inv_i(snp_inv_i), .snp_rd_i(snp_rd_i), .fill_i(fill_i),
        .rd_flags_i(rd_flags_i), .promote_i(promote_i), .pop_i(pop_i),
        .dealloc_i(dealloc_i), .valid_o(valid_o), .addr_o(addr_o),
        .in_svc_o(in_svc_o), .pend_mod_o(pend_mod_o), .post_inv_o(post_inv_o),
        .post_dg_o(post_dg_o), .flag_err_o(flag_err_o), .head_id_o(head_id_o),
        .head_ready_o(head_ready_o), .head_order_o(head_order_o),
        .head_src_o(head_src_o), .head_mark_o(head_mark_o), .head_kind_o(head_kind_o),
        .tgt_count_o(tgt_count_o), .has_tgt_o(has_tgt_o), .prim_nw_o(prim_nw_o),
        .prim_hu_o(prim_hu_o), .def_nw_o(def_nw_o), .def_hu_o(def_hu_o),
        .stall_o(stall_o), .pop_err_o(pop_err_o), .promote_ok_o(promote_ok_o)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [7:0] pq_id[$], dq_id[$];
    logic [2:0] pq_k[$], dq_k[$];
    logic m_valid = 0, m_svc = 0, m_pm = 0, m_pinv = 0, m_pdg = 0;
    logic m_pnw = 0, m_phu = 0, m_dnw = 0, m_dhu = 0;
    logic [31:0] m_addr = '0;
    logic e_stall = 0, e_perr = 0, e_ferr = 0, e_prom = 0;

    function automatic logic f_nw(input logic [2:0] k);
        return (k == 3'd1) || (k == 3'd2) || (k == 3'd3);
    endfunction
    function automatic logic f_up(input logic [2:0] k);
        return (k == 3'd2) || (k == 3'd3);
    endfunction
    function automatic logic [2:0] f_conv(input logic [2:0] k);
        return (k == 3'd2) ? 3'd1 : (k == 3'd3) ? 3'd4 : k;
    endfunction

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        chk({"R1/R2 valid ", ctx}, valid_o, m_valid);
        if (m_valid) chk({"R2 addr ", ctx}, addr_o, m_addr);
        chk({"R4 in_svc ", ctx}, in_svc_o, m_svc);
        chk({"R4 pend_mod ", ctx}, pend_mod_o, m_pm);
        chk({"R4 post_inv ", ctx}, post_inv_o, m_pinv);
        chk({"R4 post_dg ", ctx}, post_dg_o, m_pdg);
        chk({"R9 count ", ctx}, tgt_count_o, 64'(pq_id.size() + dq_id.size()));
        chk({"R9 has_tgt ", ctx}, has_tgt_o, pq_id.size() != 0);
        chk({"R7 prim_nw ", ctx}, prim_nw_o, m_pnw);
        chk({"R7 prim_hu ", ctx}, prim_hu_o, m_phu);
        chk({"R7 def_nw ", ctx}, def_nw_o, m_dnw);
        chk({"R7 def_hu ", ctx}, def_hu_o, m_dhu);
        chk({"R11 stall ", ctx}, stall_o, e_stall);
        chk({"R12 pop_err ", ctx}, pop_err_o, e_perr);
        chk({"R5 flag_err ", ctx}, flag_err_o, e_ferr);
        chk({"R10 promote_ok ", ctx}, promote_ok_o, e_prom);
        if (pq_id.size() != 0) begin
            chk({"R3 head id ", ctx}, head_id_o, pq_id[0]);
            chk({"R3 head kind ", ctx}, head_kind_o, pq_k[0]);
            chk({"R3 head ready ", ctx}, head_ready_o, 16'(pq_id[0]) * 16'd3);
            chk({"R3 head order ", ctx}, head_order_o, 16'(pq_id[0]) + 16'd100);
            chk({"R3 head src ", ctx}, head_src_o, 2'(pq_id[0] % 3));
            chk({"R3 head mark ", ctx}, head_mark_o, pq_id[0][0]);
        end
    endtask

    task automatic set_tgt(input logic [7:0] id, input logic [2:0] k);
        tgt_id_i    = id;
        tgt_ready_i = 16'(id) * 16'd3;
        tgt_order_i = 16'(id) + 16'd100;
        tgt_src_i   = 2'(id % 3);
        tgt_mark_i  = id[0];
        tgt_kind_i  = k;
    endtask

    task automatic clear_in();
        alloc_i = 0; add_i = 0; svc_i = 0; svc_pend_mod_i = 0; snp_inv_i = 0;
        snp_rd_i = 0; fill_i = 0; rd_flags_i = 0; promote_i = 0; pop_i = 0;
        dealloc_i = 0;
        e_stall = 0; e_perr = 0; e_ferr = 0; e_prom = 0;
    endtask

    task automatic tick(input string ctx);
        @(negedge clk);
        check_all(ctx);
        clear_in();
    endtask

    task automatic op_alloc(input logic [31:0] a, input logic [7:0] id, input logic [2:0] k);
        alloc_i = 1; alloc_addr_i = a; set_tgt(id, k);
        m_valid = 1; m_addr = a; m_svc = 0; m_pm = 0; m_pinv = 0; m_pdg = 0;
        pq_id = {id}; pq_k = {k}; dq_id = {}; dq_k = {};
        m_pnw = f_nw(k); m_phu = f_up(k); m_dnw = 0; m_dhu = 0;
        tick("R2 alloc");
    endtask

    task automatic op_add(input logic [7:0] id, input logic [2:0] k);
        logic todef;
        add_i = 1; set_tgt(id, k);
        todef = f_nw(k) && m_svc && !m_pm;
        if (todef) begin
            if (dq_id.size() == DEPTH) e_stall = 1;
            else begin dq_id.push_back(id); dq_k.push_back(k);
                       m_dnw |= f_nw(k); m_dhu |= f_up(k); end
        end else begin
            if (pq_id.size() == DEPTH) e_stall = 1;
            else begin pq_id.push_back(id); pq_k.push_back(k);
                       m_pnw |= f_nw(k); m_phu |= f_up(k); end
        end
        tick("R6 add");
    endtask

    task automatic op_pop();
        pop_i = 1;
        if (pq_id.size() == 0) e_perr = 1;
        else begin void'(pq_id.pop_front()); void'(pq_k.pop_front()); end
        tick("R3 pop");
    endtask

    task automatic op_svc(input logic pm);
        svc_i = 1; svc_pend_mod_i = pm;
        if (m_valid && !m_svc) begin m_svc = 1; m_pm = pm; m_pinv = 0; m_pdg = 0; end
        tick("R4 svc");
    endtask

    task automatic op_snp(input logic inv, input logic rd);
        snp_inv_i = inv; snp_rd_i = rd;
        if (m_svc) begin
            m_pinv |= inv; m_pdg |= rd;
        end else if (m_valid && inv) begin
            foreach (pq_k[i]) pq_k[i] = f_conv(pq_k[i]);
            foreach (dq_k[i]) dq_k[i] = f_conv(dq_k[i]);
            m_phu = 0; m_dhu = 0;
        end
        tick("R8 snoop");
    endtask

    task automatic op_fill();
        fill_i = 1;
        if (m_svc) begin m_svc = 0; m_pm = 0; m_pinv = 0; m_pdg = 0; end
        tick("R4 fill");
    endtask

    task automatic op_rdf();
        rd_flags_i = 1; e_ferr = !m_svc;
        tick("R5 read flags");
    endtask

    task automatic op_prom();
        promote_i = 1;
        if (m_valid && pq_id.size() == 0 && dq_id.size() != 0) begin
            pq_id = dq_id; pq_k = dq_k; dq_id = {}; dq_k = {};
            m_pnw = m_dnw; m_phu = m_dhu; m_dnw = 0; m_dhu = 0; e_prom = 1;
        end
        tick("R10 promote");
    endtask

    task automatic op_dealloc();
        dealloc_i = 1;
        m_valid = 0; m_svc = 0; m_pm = 0; m_pinv = 0; m_pdg = 0;
        pq_id = {}; pq_k = {}; dq_id = {}; dq_k = {};
        m_pnw = 0; m_phu = 0; m_dnw = 0; m_dhu = 0;
        tick("R1 dealloc");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");

        // R2 R3 R7 R11 R12: fill the primary queue with every kind mix.
        for (int pat = 0; pat < 5; pat++) begin
            op_alloc(32'h1000 + 32'(pat) * 64, 8'(pat * 16), 3'(pat));
            for (int j = 1; j < DEPTH; j++) op_add(8'(pat * 16 + j), 3'((pat + j) % 5));
            op_add(8'(pat * 16 + 15), 3'd0);          // R11 full primary
            for (int j = 0; j < DEPTH; j++) op_pop();
            op_pop();                                  // R12 empty pop
            op_dealloc();
        end

        // R4 R5 R6 R10: service with and without pending-modified.
        for (int pm = 0; pm < 2; pm++) begin
            op_alloc(32'h2000, 8'h80, 3'd0);
            op_rdf();
            op_svc(pm[0]);
            op_rdf();
            for (int k = 0; k < 5; k++) op_add(8'(8'h81 + k), 3'(k));
            op_snp(1'b0, 1'b1);
            op_snp(1'b1, 1'b0);
            op_rdf();
            op_fill();
            op_rdf();
            while (pq_id.size() != 0) op_pop();
            op_pop();
            op_prom();
            while (pq_id.size() != 0) op_pop();
            op_prom();
            op_dealloc();
        end

        // R8: upgrade rewriting outside service, in both queues.
        op_alloc(32'h3000, 8'h40, 3'd0);
        op_add(8'h41, 3'd2);
        op_add(8'h42, 3'd3);
        op_add(8'h43, 3'd1);
        op_add(8'h44, 3'd4);
        op_snp(1'b1, 1'b1);
        op_svc(1'b0);
        op_add(8'h50, 3'd2);
        op_add(8'h51, 3'd3);
        op_fill();
        op_snp(1'b1, 1'b0);
        while (pq_id.size() != 0) op_pop();
        op_prom();
        while (pq_id.size() != 0) op_pop();
        op_dealloc();

        // R10 R11: full deferred queue, promotion blocked by primary.
        op_alloc(32'h4000, 8'h60, 3'd0);
        op_svc(1'b0);
        for (int j = 0; j < DEPTH; j++) op_add(8'(8'h61 + j), 3'(1 + j % 3));
        op_add(8'h70, 3'd1);
        op_prom();
        op_fill();
        op_pop();
        op_prom();
        op_add(8'h71, 3'd0);
        op_dealloc();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule